// File: doc/BRIEF.md
# Thread Block Resource Admission Unit

This unit sits in front of one multiprocessor and decides whether an incoming thread block may become resident. Every request names three demands: a thread count, a number of 32-bit registers and a number of shared-memory bytes. The unit holds running totals of the thread slots, registers and shared-memory bytes already reserved, plus a record of which resident-block slots are taken. A block is admitted only when every pool, and the resident-block cap, has room for it at once. On admission the amounts are reserved and a slot number is returned. When the block finishes, the slot number is handed back on a release port and exactly the recorded amounts are returned to the pools.

Requests use a valid/ready handshake. A request that fits now is taken at once. A request that is legal but does not fit now is held with ready low until releases free enough room. A request that could not fit even on an idle multiprocessor is taken at once and answered with a reject response, so it never blocks the port. A release and an admission in the same cycle are ordered release first, so capacity and a slot freed in that cycle can be given to the waiting request in the same cycle.

Top module: `blk_admit_unit`

## Requirements
- R1: After reset all four usage outputs (`used_threads`, `used_regs`, `used_smem`, `used_blocks`) are zero and `resp_valid` is low.
- R2: A request with thread count 0, thread count above 512, register demand above 8192 or shared-memory demand above 16384 bytes is illegal: `req_ready` is high for it whatever the occupancy, one cycle after the transfer `resp_valid`=1 with `resp_reject`=1 and `resp_slot`=0, and no usage output changes because of it.
- R3: A legal request is accepted only if, after it, reserved threads stay at or below 768, registers at or below 8192 and shared memory at or below 16384 bytes; otherwise `req_ready` is low.
- R4: One cycle after a legal transfer `resp_valid`=1, `resp_reject`=0 and `resp_slot` is the lowest-numbered free slot; in that same cycle each usage output has grown by the request's amount and `used_blocks` by one.
- R5: At most 8 blocks are resident; with 8 resident a legal request is held with `req_ready` low.
- R6: A release of an occupied slot returns exactly the thread, register and shared-memory amounts recorded for that slot at admission, lowers `used_blocks` by one and makes the slot free, visible on the usage outputs one cycle later.
- R7: A release that names a free slot is ignored: no usage output changes because of it.
- R8: When a release and a request arrive in the same cycle, the release is applied first: the freed amounts and the freed slot count toward `req_ready` in that cycle, and the freed slot may be the one returned.
- R9: A legal request that does not fit is held, not dropped: while it waits no response is issued, and once releases make room it is accepted with the normal grant response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Admission request present |
| req_ready | output | 1 | Request taken this cycle (fits or is illegal) |
| req_threads | input | 10 | Threads in the requested block |
| req_regs | input | 14 | Registers demanded by the block |
| req_smem | input | 15 | Shared-memory bytes demanded by the block |
| rel_valid | input | 1 | Release of a resident block |
| rel_slot | input | 3 | Slot number being released |
| resp_valid | output | 1 | Response for the request taken in the previous cycle |
| resp_reject | output | 1 | 1 = illegal request rejected, 0 = granted |
| resp_slot | output | 3 | Slot granted (0 on reject) |
| used_threads | output | 10 | Threads currently reserved |
| used_regs | output | 14 | Registers currently reserved |
| used_smem | output | 15 | Shared-memory bytes currently reserved |
| used_blocks | output | 4 | Blocks currently resident |

## Verification
On every cycle the assertions check that no pool exceeds its capacity, that a release never returns more than is reserved, that a grant is only made when a free slot exists and is answered with a grant response, that an illegal request and a release of a free slot leave the totals untouched, and that a held request produces no response. Which slot is chosen, that the exact recorded amounts come back on release, and the release-first ordering in a shared cycle are shown only by the bench scenarios, which fill each pool and the slot cap to its limit, hold a request against it and then free room, comparing every output against the behavioural model each cycle.

// File: rtl/blk_admit_pkg.sv
package blk_admit_pkg;

   typedef enum logic [0:0] {
      RSP_GRANT  = 1'b0,
      RSP_REJECT = 1'b1
   } rsp_kind_e;

   // bits needed to hold every value from 0 up to maxval
   function automatic int width_for(input int maxval);
      return (maxval < 2) ? 1 : $clog2(maxval + 1);
   endfunction

endpackage

// File: rtl/blk_pool_ctr.sv
module blk_pool_ctr
   import blk_admit_pkg::*;
#(
   parameter int CAP = 768,
   localparam int W  = width_for(CAP)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] cand,
   input  logic         take_en,
   input  logic         give_en,
   input  logic [W-1:0] give_amt,
   output logic         fits,
   output logic [W-1:0] used
);

   localparam int EW = W + 1;

   logic [EW-1:0] after_give;
   logic [EW-1:0] with_cand;
   logic [EW-1:0] next_used;

   initial begin
      assert (CAP > 0) else $error("pool capacity must be positive");
   end

   // release is applied before the candidate is weighed
   always_comb begin
      after_give = EW'(used) - (give_en ? EW'(give_amt) : EW'(0));
      with_cand  = after_give + EW'(cand);
      fits       = (with_cand <= EW'(CAP));
      next_used  = take_en ? with_cand : after_give;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) used <= '0;
      else        used <= next_used[W-1:0];
   end

   AST_POOL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      used <= W'(CAP)); // R3

   AST_GIVE_COVERED: assert property (@(posedge clk) disable iff (!rst_n)
      give_en |-> (give_amt <= used)); // R6

   AST_TAKE_FITS: assert property (@(posedge clk) disable iff (!rst_n)
      take_en |=> (used <= W'(CAP))); // R3

endmodule

// File: rtl/blk_slot_table.sv
module blk_slot_table
   import blk_admit_pkg::*;
#(
   parameter int NSLOT = 8,
   parameter int TW    = 10,
   parameter int RW    = 14,
   parameter int SW    = 15,
   localparam int SLW  = (NSLOT > 1) ? $clog2(NSLOT) : 1,
   localparam int CW   = width_for(NSLOT)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           alloc_en,
   input  logic [TW-1:0]  alloc_thr,
   input  logic [RW-1:0]  alloc_reg,
   input  logic [SW-1:0]  alloc_smem,
   input  logic           rel_valid,
   input  logic [SLW-1:0] rel_slot,
   output logic           rel_hit,
   output logic [TW-1:0]  rel_thr,
   output logic [RW-1:0]  rel_reg,
   output logic [SW-1:0]  rel_smem,
   output logic           free_any,
   output logic [SLW-1:0] free_idx,
   output logic [CW-1:0]  occ_cnt
);

   logic [NSLOT-1:0] occ_q;
   logic [NSLOT-1:0] free_mask;
   logic [TW-1:0]    rec_thr  [NSLOT];
   logic [RW-1:0]    rec_reg  [NSLOT];
   logic [SW-1:0]    rec_smem [NSLOT];

   initial begin
      assert (NSLOT >= 2 && (NSLOT & (NSLOT - 1)) == 0)
         else $error("slot count must be a power of two, at least 2");
   end

   assign rel_hit  = rel_valid && occ_q[rel_slot];
   assign rel_thr  = rec_thr[rel_slot];
   assign rel_reg  = rec_reg[rel_slot];
   assign rel_smem = rec_smem[rel_slot];

   // a slot being released this cycle already counts as free
   always_comb begin
      free_mask = ~occ_q;
      if (rel_hit) free_mask[rel_slot] = 1'b1;
   end

   always_comb begin
      free_any = 1'b0;
      free_idx = '0;
      for (int i = NSLOT - 1; i >= 0; i--) begin
         if (free_mask[i]) begin
            free_any = 1'b1;
            free_idx = SLW'(i);
         end
      end
   end

   always_comb begin
      occ_cnt = '0;
      for (int i = 0; i < NSLOT; i++) occ_cnt = occ_cnt + CW'(occ_q[i]);
   end

   for (genvar g = 0; g < NSLOT; g++) begin : g_slot
      logic alloc_here;
      logic rel_here;
      assign alloc_here = alloc_en && (free_idx == SLW'(g));
      assign rel_here   = rel_hit && (rel_slot == SLW'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            occ_q[g]    <= 1'b0;
            rec_thr[g]  <= '0;
            rec_reg[g]  <= '0;
            rec_smem[g] <= '0;
         end else if (alloc_here) begin
            occ_q[g]    <= 1'b1;
            rec_thr[g]  <= alloc_thr;
            rec_reg[g]  <= alloc_reg;
            rec_smem[g] <= alloc_smem;
         end else if (rel_here) begin
            occ_q[g]    <= 1'b0;
         end
      end
   end

   AST_ALLOC_HAS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_en |-> free_any); // R5

   AST_ALLOC_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_en && !rel_hit) |=> (occ_cnt == $past(occ_cnt) + CW'(1))); // R4

   AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rel_hit && !alloc_en) |=> (occ_cnt == $past(occ_cnt) - CW'(1))); // R6

endmodule

// File: rtl/blk_admit_unit.sv
module blk_admit_unit
   import blk_admit_pkg::*;
#(
   parameter int MAX_BLOCKS      = 8,
   parameter int MAX_THREADS     = 768,
   parameter int MAX_BLK_THREADS = 512,
   parameter int REG_POOL        = 8192,
   parameter int SMEM_BYTES      = 16384,
   localparam int TW  = width_for(MAX_THREADS),
   localparam int RW  = width_for(REG_POOL),
   localparam int SW  = width_for(SMEM_BYTES),
   localparam int SLW = (MAX_BLOCKS > 1) ? $clog2(MAX_BLOCKS) : 1,
   localparam int CW  = width_for(MAX_BLOCKS)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           req_valid,
   output logic           req_ready,
   input  logic [TW-1:0]  req_threads,
   input  logic [RW-1:0]  req_regs,
   input  logic [SW-1:0]  req_smem,
   input  logic           rel_valid,
   input  logic [SLW-1:0] rel_slot,
   output logic           resp_valid,
   output logic           resp_reject,
   output logic [SLW-1:0] resp_slot,
   output logic [TW-1:0]  used_threads,
   output logic [RW-1:0]  used_regs,
   output logic [SW-1:0]  used_smem,
   output logic [CW-1:0]  used_blocks
);

   initial begin
      assert (MAX_BLK_THREADS >= 1 && MAX_BLK_THREADS <= MAX_THREADS)
         else $error("largest block must lie between 1 and the thread pool");
      assert (REG_POOL > 0 && SMEM_BYTES > 0)
         else $error("register and shared-memory pools must be non-empty");
   end

   logic           invalid;
   logic           fit_thr, fit_reg, fit_smem;
   logic           fit_all;
   logic           xfer;
   logic           commit;
   logic           rel_hit;
   logic [TW-1:0]  rel_thr;
   logic [RW-1:0]  rel_reg;
   logic [SW-1:0]  rel_smem;
   logic           free_any;
   logic [SLW-1:0] free_idx;
   rsp_kind_e      kind;

   // a request that cannot fit an idle multiprocessor is illegal
   assign invalid = (req_threads == '0)
                 || (req_threads > TW'(MAX_BLK_THREADS))
                 || (req_regs    > RW'(REG_POOL))
                 || (req_smem    > SW'(SMEM_BYTES));

   assign fit_all   = free_any && fit_thr && fit_reg && fit_smem;
   assign req_ready = invalid || fit_all;
   assign xfer      = req_valid && req_ready;
   assign commit    = xfer && !invalid;
   assign kind      = invalid ? RSP_REJECT : RSP_GRANT;

   blk_slot_table #(
      .NSLOT (MAX_BLOCKS),
      .TW    (TW),
      .RW    (RW),
      .SW    (SW)
   ) slots_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc_en   (commit),
      .alloc_thr  (req_threads),
      .alloc_reg  (req_regs),
      .alloc_smem (req_smem),
      .rel_valid  (rel_valid),
      .rel_slot   (rel_slot),
      .rel_hit    (rel_hit),
      .rel_thr    (rel_thr),
      .rel_reg    (rel_reg),
      .rel_smem   (rel_smem),
      .free_any   (free_any),
      .free_idx   (free_idx),
      .occ_cnt    (used_blocks)
   );

   blk_pool_ctr #(.CAP(MAX_THREADS)) thr_pool_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .cand     (req_threads),
      .take_en  (commit),
      .give_en  (rel_hit),
      .give_amt (rel_thr),
      .fits     (fit_thr),
      .used     (used_threads)
   );

   blk_pool_ctr #(.CAP(REG_POOL)) reg_pool_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .cand     (req_regs),
      .take_en  (commit),
      .give_en  (rel_hit),
      .give_amt (rel_reg),
      .fits     (fit_reg),
      .used     (used_regs)
   );

   blk_pool_ctr #(.CAP(SMEM_BYTES)) smem_pool_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .cand     (req_smem),
      .take_en  (commit),
      .give_en  (rel_hit),
      .give_amt (rel_smem),
      .fits     (fit_smem),
      .used     (used_smem)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         resp_valid  <= 1'b0;
         resp_reject <= 1'b0;
         resp_slot   <= '0;
      end else begin
         resp_valid <= xfer;
         if (xfer) begin
            resp_reject <= (kind == RSP_REJECT);
            resp_slot   <= invalid ? '0 : free_idx;
         end
      end
   end

   AST_REJECT_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer && invalid && !rel_hit) |=>
         ($stable(used_threads) && $stable(used_regs) && $stable(used_smem)
          && $stable(used_blocks))); // R2

   AST_GRANT_RESP: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> (resp_valid && !resp_reject)); // R4

   AST_IGNORE_FREE_REL: assert property (@(posedge clk) disable iff (!rst_n)
      (rel_valid && !rel_hit && !commit) |=>
         ($stable(used_threads) && $stable(used_regs) && $stable(used_smem)
          && $stable(used_blocks))); // R7

   AST_HELD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=> !resp_valid); // R9

   AST_BLOCK_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (used_blocks == CW'(MAX_BLOCKS) && !rel_hit) |-> !commit); // R5

endmodule

// File: tb/blk_admit_unit_tb_top.sv
`timescale 1ns/1ps
module blk_admit_unit_tb_top;

   localparam int NB   = 8;
   localparam int MTHR = 768;
   localparam int MBLK = 512;
   localparam int MREG = 8192;
   localparam int MSM  = 16384;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [9:0]  req_threads = '0;
   logic [13:0] req_regs = '0;
   logic [14:0] req_smem = '0;
   logic        rel_valid = 1'b0;
   logic [2:0]  rel_slot = '0;
   logic        resp_valid;
   logic        resp_reject;
   logic [2:0]  resp_slot;
   logic [9:0]  used_threads;
   logic [13:0] used_regs;
   logic [14:0] used_smem;
   logic [3:0]  used_blocks;

   always #2.5 clk = ~clk;

   blk_admit_unit dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_ready    (req_ready),
      .req_threads  (req_threads),
      .req_regs     (req_regs),
      .req_smem     (req_smem),
      .rel_valid    (rel_valid),
      .rel_slot     (rel_slot),
      .resp_valid   (resp_valid),
      .resp_reject  (resp_reject),
      .resp_slot    (resp_slot),
      .used_threads (used_threads),
      .used_regs    (used_regs),
      .used_smem    (used_smem),
      .used_blocks  (used_blocks)
   );

   // behavioural reference model
   bit m_occ [NB];
   int m_t [NB];
   int m_r [NB];
   int m_s [NB];
   int tot_t, tot_r, tot_s;
   bit m_rv, m_rrej;
   int m_rslot;

   int    n_chk = 0;
   int    n_fail = 0;
   string cur_tag = "R1";

   function automatic void evaluate(output bit rdy, output bit inv,
                                    output int slot, output bit rel_act);
      int t, r, s;
      bit fit;
      rel_act = rel_valid && m_occ[rel_slot];
      t = tot_t - (rel_act ? m_t[rel_slot] : 0);
      r = tot_r - (rel_act ? m_r[rel_slot] : 0);
      s = tot_s - (rel_act ? m_s[rel_slot] : 0);
      slot = -1;
      for (int i = NB - 1; i >= 0; i--)
         if (!m_occ[i] || (rel_act && int'(rel_slot) == i)) slot = i;
      inv = (req_threads == 0) || (req_threads > MBLK) ||
            (req_regs > MREG) || (req_smem > MSM);
      fit = (slot >= 0) && (t + req_threads <= MTHR) &&
            (r + req_regs <= MREG) && (s + req_smem <= MSM);
      rdy = inv || fit;
   endfunction

   always @(posedge clk) begin
      bit rdy, inv, ra;
      int slot;
      if (!rst_n) begin
         for (int i = 0; i < NB; i++) begin
            m_occ[i] = 0; m_t[i] = 0; m_r[i] = 0; m_s[i] = 0;
         end
         tot_t = 0; tot_r = 0; tot_s = 0;
         m_rv = 0; m_rrej = 0; m_rslot = 0;
      end else begin
         evaluate(rdy, inv, slot, ra);
         if (ra) begin
            tot_t -= m_t[rel_slot];
            tot_r -= m_r[rel_slot];
            tot_s -= m_s[rel_slot];
            m_occ[rel_slot] = 0;
         end
         m_rv = req_valid && rdy;
         if (m_rv) begin
            m_rrej  = inv;
            m_rslot = inv ? 0 : slot;
            if (!inv) begin
               m_occ[slot] = 1;
               m_t[slot] = int'(req_threads);
               m_r[slot] = int'(req_regs);
               m_s[slot] = int'(req_smem);
               tot_t += int'(req_threads);
               tot_r += int'(req_regs);
               tot_s += int'(req_smem);
            end
         end
      end
   end

   task automatic check(string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", cur_tag, what, act, exp);
      end
   endtask

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      bit rdy, inv, ra;
      int slot, blocks;
      evaluate(rdy, inv, slot, ra);
      blocks = 0;
      for (int i = 0; i < NB; i++) blocks += m_occ[i];
      if (rst_n) check("req_ready", int'(req_ready), int'(rdy));
      check("resp_valid", int'(resp_valid), int'(m_rv));
      if (m_rv) begin
         check("resp_reject", int'(resp_reject), int'(m_rrej));
         check("resp_slot", int'(resp_slot), m_rslot);
      end
      check("used_threads", int'(used_threads), tot_t);
      check("used_regs", int'(used_regs), tot_r);
      check("used_smem", int'(used_smem), tot_s);
      check("used_blocks", int'(used_blocks), blocks);
   end

   task automatic drive(bit rv, int thr, int rg, int sm, bit lv, int ls);
      req_valid   = rv;
      req_threads = 10'(thr);
      req_regs    = 14'(rg);
      req_smem    = 15'(sm);
      rel_valid   = lv;
      rel_slot    = 3'(ls);
      @(posedge clk);
      #1;
   endtask

   task automatic idle();
      drive(0, 0, 0, 0, 0, 0);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired in phase %s", cur_tag);
      summary();
      $finish;
   end

   initial begin
      cur_tag = "R1";
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset used_threads", int'(used_threads), 0);
      check("R1 reset used_blocks", int'(used_blocks), 0);
      check("R1 reset resp_valid", int'(resp_valid), 0);
      @(posedge clk); #1;

      cur_tag = "R2";
      drive(1, 0, 10, 10, 0, 0);
      drive(1, 513, 10, 10, 0, 0);
      drive(1, 10, 8193, 0, 0, 0);
      drive(1, 10, 0, 16385, 0, 0);
      idle();

      cur_tag = "R4";
      drive(1, 256, 1024, 2048, 0, 0);
      drive(1, 256, 1024, 2048, 0, 0);
      drive(1, 256, 1024, 2048, 0, 0);
      idle();

      cur_tag = "R3";
      drive(1, 1, 0, 0, 0, 0);
      cur_tag = "R9";
      drive(1, 1, 0, 0, 0, 0);
      drive(1, 1, 0, 0, 0, 0);
      drive(1, 1, 0, 0, 0, 0);

      cur_tag = "R8";
      drive(1, 1, 0, 0, 1, 1);
      idle();

      cur_tag = "R6";
      drive(0, 0, 0, 0, 1, 0);
      drive(0, 0, 0, 0, 1, 2);
      drive(0, 0, 0, 0, 1, 1);
      idle();

      cur_tag = "R7";
      drive(0, 0, 0, 0, 1, 5);
      drive(1, 100, 200, 300, 0, 0);
      drive(0, 0, 0, 0, 1, 3);
      drive(0, 0, 0, 0, 1, 0);
      drive(0, 0, 0, 0, 1, 0);
      idle();

      cur_tag = "R3";
      drive(1, 64, 8192, 0, 0, 0);
      drive(1, 64, 1, 0, 0, 0);
      drive(1, 64, 1, 0, 0, 0);
      cur_tag = "R8";
      drive(1, 64, 1, 0, 1, 0);
      drive(0, 0, 0, 0, 1, 0);
      idle();

      cur_tag = "R3";
      drive(1, 32, 0, 16384, 0, 0);
      cur_tag = "R9";
      drive(1, 32, 0, 1, 0, 0);
      drive(1, 32, 0, 1, 0, 0);
      drive(0, 0, 0, 0, 1, 0);
      drive(1, 32, 0, 1, 0, 0);
      drive(0, 0, 0, 0, 1, 0);
      idle();

      cur_tag = "R5";
      for (int k = 0; k < NB; k++) drive(1, 32, 16, 16, 0, 0);
      drive(1, 1, 1, 1, 0, 0);
      drive(1, 1, 1, 1, 0, 0);
      cur_tag = "R2";
      drive(1, 600, 1, 1, 0, 0);
      cur_tag = "R9";
      drive(1, 1, 1, 1, 0, 0);
      drive(0, 0, 0, 0, 1, 3);
      drive(1, 1, 1, 1, 0, 0);
      idle();

      cur_tag = "R6";
      for (int k = 0; k < NB; k++) drive(0, 0, 0, 0, 1, k);
      idle();
      idle();

      summary();
      $finish;
   end

endmodule